// File: doc/BRIEF.md
# Bit-Serial Configurable Feistel Round Engine

This block is the round datapath of a compact Feistel block cipher that handles one bit of state per clock. The two halves of the block, upper and lower, each n bits wide, sit in serial shift storage. On every clock the block reads one round-key bit, forms one bit of the new upper word and moves one bit of the old upper word into the lower store. The word size is picked at run time from five values (16, 24, 32, 48 or 64 bits) by a 4-bit configuration code. Unused stretches of storage are bypassed, so the same hardware serves every size.

The round function needs the upper word rotated left by 1, 2 and 8. A serial stream cannot reach back into its own storage. The eight most significant upper bits therefore live in two 8-bit registers that trade roles on each round. One register holds a sliding window of the last eight upper bits, which supplies all three taps. The other collects freshly computed bits, so that they do not overwrite old bits that are still needed.

An outside controller owns the key schedule and the round count. After a start, it supplies one key bit per clock, LSB first, and the LSB of its round counter. It raises `final_i` during the last round. When that round ends the block shows the ciphertext in parallel and raises `done_o`.

Top module: `fsr_round_engine`

## Requirements
- R1: Configuration codes 1..10 select word sizes 16, 24, 24, 32, 32, 48, 48, 64, 64, 64 in that order. A start with code 0 or 11..15 is refused: `busy_o` stays low, and `done_o` and the ciphertext outputs keep their values.
- R2: A start strobe with a legal code while idle loads `pt_hi_i[n-1:0]` as the upper word and `pt_lo_i[n-1:0]` as the lower word. Input bits at and above n are ignored. On the next cycle `busy_o` is 1, `bit_idx_o` is 0 and `done_o` is 0.
- R3: A round lasts exactly n clocks. `bit_idx_o` counts 0..n-1 within the round, and `round_end_o` is high only in the cycle where `bit_idx_o` equals n-1.
- R4: While busy, in the cycle with bit index j, `fbit_o` equals L[j] ^ K[j] ^ (U[j-1] & U[j-8]) ^ U[j-2]. U and L are the current upper and lower words, indices are taken modulo n, and K[j] is `key_bit_i` in that cycle.
- R5: After each round the lower word equals the previous upper word, and the upper word equals the n bits delivered on `fbit_o` during that round.
- R6: If `final_i` is high in the cycle where `round_end_o` is high, then on the next cycle `busy_o` is 0 and `done_o` is 1. `ct_hi_o` and `ct_lo_o` then carry the upper and lower words, with zeros above bit n-1.
- R7: While busy, `start_i`, `cfg_i`, `pt_hi_i` and `pt_lo_i` have no effect on the computation.
- R8: The controller presents round-LSB 0 in the first round and toggles it after each round end. The result is correct for odd and for even round counts.
- R9: After reset, `busy_o`, `done_o`, `fbit_o`, `round_end_o`, `ct_hi_o` and `ct_lo_o` are all zero.
- R10: `done_o` and the ciphertext outputs hold steady until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 4 | Security configuration code, sampled on an accepted start |
| start_i | input | 1 | Start strobe; loads the plaintext when idle |
| pt_hi_i | input | 64 | Plaintext upper word (low n bits used) |
| pt_lo_i | input | 64 | Plaintext lower word (low n bits used) |
| key_bit_i | input | 1 | Round-key bit for the current bit index |
| round_lsb_i | input | 1 | LSB of the controller's round counter |
| final_i | input | 1 | Marks the current round as the last one |
| busy_o | output | 1 | Rounds in progress |
| bit_idx_o | output | 6 | Bit position processed in this cycle |
| round_end_o | output | 1 | Last bit of the current round |
| fbit_o | output | 1 | New upper-word bit computed this cycle |
| done_o | output | 1 | Ciphertext valid |
| ct_hi_o | output | 64 | Ciphertext upper word |
| ct_lo_o | output | 64 | Ciphertext lower word |

## Verification
Every legal configuration code is run with four plaintext kinds:
- **Random words with random upper input bits.** These show that bits above n are ignored.
- **An all-ones upper word over a zero lower word.** This isolates the AND and the rotate-by-2 term from the lower-word path.
- **A single set bit at position n-1.** This is the bit that has to wrap through the tap window into bits 0, 1 and 7 of the next word. It exposes a wrong tap or a wrong window length.
- **A long random run with a mid-round start strobe carrying another code.** This tests that busy-time inputs are ignored.

Round counts 1 to 4 cover both final parities of the ping-pong pair. Each computed bit is compared with a word-level reference round. The final parallel result, refused illegal codes and the hold after completion are checked at the ports.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int WMAX  = 64;
  localparam int TAP   = 8;
  localparam int NLVL  = 5;
  localparam int CFG_W = 4;
  localparam int NCFG  = 10;
  localparam int IDX_W = $clog2(WMAX);
  localparam int LEN_W = IDX_W + 1;
  localparam int LVL_W = $clog2(NLVL);

  // Word size of each storage level.
  function automatic int lvl_width(input int l);
    case (l)
      0: return 16;
      1: return 24;
      2: return 32;
      3: return 48;
      default: return 64;
    endcase
  endfunction

  // Offset of segment k inside a store whose top HEAD bits live elsewhere.
  function automatic int seg_base(input int k, input int head);
    if (k == 0) return 0;
    return lvl_width(k - 1) - head;
  endfunction

  function automatic int seg_len(input int k, input int head);
    return lvl_width(k) - head - seg_base(k, head);
  endfunction

  function automatic logic [WMAX-1:0] low_mask(input int nb);
    if (nb >= WMAX) return '1;
    if (nb <= 0) return '0;
    return (WMAX'(1) << nb) - WMAX'(1);
  endfunction

  function automatic logic cfg_legal(input logic [CFG_W-1:0] c);
    return (c >= CFG_W'(1)) && (c <= CFG_W'(NCFG));
  endfunction

  // Codes pair up onto levels; the top three codes share the widest level.
  function automatic logic [LVL_W-1:0] cfg_level(input logic [CFG_W-1:0] c);
    if (c >= CFG_W'(8)) return LVL_W'(NLVL - 1);
    return LVL_W'(c >> 1);
  endfunction

  // One output bit of the round: taps are the upper bits 1, 2 and 8 places back.
  function automatic logic round_bit(input logic u_m1, input logic u_m2,
                                     input logic u_m8, input logic l_j,
                                     input logic k_j);
    return l_j ^ k_j ^ (u_m1 & u_m8) ^ u_m2;
  endfunction
endpackage

// File: rtl/fsr_cfg_decode.sv
module fsr_cfg_decode
  import fsr_pkg::*;
(
  input  logic [CFG_W-1:0] cfg,
  output logic             legal,
  output logic [LVL_W-1:0] lvl,
  output logic [LEN_W-1:0] wlen
);
  always_comb begin
    legal = cfg_legal(cfg);
    lvl   = cfg_level(cfg);
    wlen  = LEN_W'(lvl_width(int'(lvl)));
  end
endmodule

// File: rtl/fsr_seg_chain.sv
// Serial word store built from segments; the active length is chosen by
// steering the input into segment 'lvl' and bypassing the ones above it.
module fsr_seg_chain
  import fsr_pkg::*;
#(
  parameter int W_MAX = WMAX,
  parameter int HEAD  = 0,
  parameter int NSEG  = NLVL,
  localparam int TOT  = W_MAX - HEAD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TOT-1:0]   ld_word,
  input  logic             shift,
  input  logic [LVL_W-1:0] lvl,
  input  logic             din,
  output logic             dout,
  output logic [TOT-1:0]   word
);
  logic [TOT-1:0]  st;
  logic [NSEG-1:0] seg_in;

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    localparam int B = seg_base(k, HEAD);
    localparam int L = seg_len(k, HEAD);
    logic [L-1:0] sg;
    logic         act;

    assign act = (k <= int'(lvl));

    if (k == NSEG - 1) begin : g_top
      assign seg_in[k] = (k == int'(lvl)) ? din : 1'b0;
    end else begin : g_mid
      assign seg_in[k] = (k == int'(lvl)) ? din : st[seg_base(k + 1, HEAD)];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             sg <= '0;
      else if (load)          sg <= ld_word[B +: L];
      else if (shift && act)  sg <= {seg_in[k], sg[L-1:1]};
    end

    assign st[B +: L] = sg;
  end

  assign dout = st[0];
  assign word = st;
endmodule

// File: rtl/fsr_pingpong.sv
// Two head registers trading roles each round: the window role feeds the
// rotate taps, the collect role gathers newly computed bits.
module fsr_pingpong
  import fsr_pkg::*;
#(
  parameter int W = TAP
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ld_top,
  input  logic         shift,
  input  logic         par,
  input  logic         from_store,
  input  logic         fbit,
  input  logic         sel,
  output logic         tap1,
  output logic         tap2,
  output logic         tapw,
  output logic         col_out,
  output logic [W-1:0] top_word
);
  logic [W-1:0] rg [2];

  for (genvar i = 0; i < 2; i++) begin : g_reg
    logic [W-1:0] r;
    logic         win_role;

    assign win_role = (par == i[0]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        r <= '0;
      else if (load)     r <= (i == 0) ? ld_top : '0;
      else if (shift)    r <= win_role ? {from_store, r[W-1:1]} : {fbit, r[W-1:1]};
    end

    assign rg[i] = r;
  end

  logic [W-1:0] win, col;
  assign win      = rg[par];
  assign col      = rg[~par];
  assign tap1     = win[W-1];
  assign tap2     = win[W-2];
  assign tapw     = win[0];
  assign col_out  = col[0];
  assign top_word = rg[sel];
endmodule

// File: rtl/fsr_round_engine.sv
module fsr_round_engine
  import fsr_pkg::*;
#(
  parameter int W_MAX = WMAX,
  parameter int HW    = TAP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              start_i,
  input  logic [W_MAX-1:0]  pt_hi_i,
  input  logic [W_MAX-1:0]  pt_lo_i,
  input  logic              key_bit_i,
  input  logic              round_lsb_i,
  input  logic              final_i,
  output logic              busy_o,
  output logic [IDX_W-1:0]  bit_idx_o,
  output logic              round_end_o,
  output logic              fbit_o,
  output logic              done_o,
  output logic [W_MAX-1:0]  ct_hi_o,
  output logic [W_MAX-1:0]  ct_lo_o
);
  localparam int UTOT = W_MAX - HW;

  logic             cfg_ok;
  logic [LVL_W-1:0] cfg_lvl;
  logic [LEN_W-1:0] cfg_len;

  fsr_cfg_decode u_dec (
    .cfg  (cfg_i),
    .legal(cfg_ok),
    .lvl  (cfg_lvl),
    .wlen (cfg_len)
  );

  logic             busy_q, done_q, fin_sel_q;
  logic [IDX_W-1:0] cnt_q;
  logic [LVL_W-1:0] lvl_q;
  logic [LEN_W-1:0] wl_q;

  // Named internal events.
  logic start_acc, round_end, last_end, head_phase, step;
  assign start_acc  = start_i & ~busy_q & cfg_ok;
  assign round_end  = busy_q && (cnt_q == IDX_W'(wl_q - LEN_W'(1)));
  assign last_end   = round_end & final_i;
  assign head_phase = (cnt_q < IDX_W'(HW));
  assign step       = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      fin_sel_q <= 1'b0;
      cnt_q     <= '0;
      lvl_q     <= '0;
      wl_q      <= LEN_W'(lvl_width(0));
    end else if (start_acc) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      cnt_q  <= '0;
      lvl_q  <= cfg_lvl;
      wl_q   <= cfg_len;
    end else if (busy_q) begin
      cnt_q <= round_end ? '0 : cnt_q + IDX_W'(1);
      if (last_end) begin
        busy_q    <= 1'b0;
        done_q    <= 1'b1;
        fin_sel_q <= ~round_lsb_i;
      end
    end
  end

  // Storage and datapath.
  logic          u_out, l_out, fnew;
  logic          tap1, tap2, tapw, col_out;
  logic [HW-1:0] ld_top, top_word;
  logic [UTOT-1:0]  u_word;
  logic [W_MAX-1:0] l_word;
  logic          u_din;

  assign ld_top = HW'(pt_hi_i >> (int'(cfg_len) - HW));
  assign u_din  = head_phase ? tapw : col_out;

  fsr_seg_chain #(.W_MAX(W_MAX), .HEAD(HW)) u_upper (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (start_acc),
    .ld_word(pt_hi_i[UTOT-1:0]),
    .shift  (step),
    .lvl    (lvl_q),
    .din    (u_din),
    .dout   (u_out),
    .word   (u_word)
  );

  fsr_seg_chain #(.W_MAX(W_MAX), .HEAD(0)) u_lower (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (start_acc),
    .ld_word(pt_lo_i),
    .shift  (step),
    .lvl    (lvl_q),
    .din    (u_out),
    .dout   (l_out),
    .word   (l_word)
  );

  fsr_pingpong #(.W(HW)) u_pp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_acc),
    .ld_top    (ld_top),
    .shift     (step),
    .par       (round_lsb_i),
    .from_store(u_out),
    .fbit      (fnew),
    .sel       (fin_sel_q),
    .tap1      (tap1),
    .tap2      (tap2),
    .tapw      (tapw),
    .col_out   (col_out),
    .top_word  (top_word)
  );

  assign fnew = round_bit(tap1, tap2, tapw, l_out, key_bit_i);

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign bit_idx_o   = cnt_q;
  assign round_end_o = round_end;
  assign fbit_o      = busy_q & fnew;
  assign ct_hi_o     = done_q ? ((W_MAX'(u_word) & low_mask(int'(wl_q) - HW))
                                 | (W_MAX'(top_word) << (int'(wl_q) - HW))) : '0;
  assign ct_lo_o     = done_q ? (l_word & low_mask(int'(wl_q))) : '0;
endmodule

// File: rtl/fsr_round_checker.sv
module fsr_round_checker
  import fsr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [CFG_W-1:0] cfg_i,
  input logic             final_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             round_end_o,
  input logic [IDX_W-1:0] bit_idx_o,
  input logic [WMAX-1:0]  ct_hi_o,
  input logic [LEN_W-1:0] wl
);
  a_r1_refuse_code: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && (cfg_i == 4'd0 || cfg_i > 4'd10)) |=> !busy_o);

  a_r2_start_index: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && cfg_i >= 4'd1 && cfg_i <= 4'd10)
      |=> (busy_o && bit_idx_o == '0 && !done_o));

  a_r3_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !round_end_o) |=> (busy_o && bit_idx_o == IDX_W'($past(bit_idx_o) + 1)));

  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (round_end_o && !final_i) |=> (busy_o && bit_idx_o == '0));

  a_r6_finish: assert property (@(posedge clk) disable iff (!rst_n)
    (round_end_o && final_i) |=> (!busy_o && done_o));

  a_r7_len_stable: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(wl));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(ct_hi_o)));
endmodule

bind fsr_round_engine fsr_round_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .cfg_i      (cfg_i),
  .final_i    (final_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .round_end_o(round_end_o),
  .bit_idx_o  (bit_idx_o),
  .ct_hi_o    (ct_hi_o),
  .wl         (wl_q)
);

// File: tb/fsr_round_engine_test.sv
module fsr_round_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_i = '0;
  logic        start_i = 1'b0;
  logic [63:0] pt_hi_i = '0, pt_lo_i = '0;
  logic        key_bit_i = 1'b0, round_lsb_i = 1'b0, final_i = 1'b0;
  logic        busy_o, round_end_o, fbit_o, done_o;
  logic [5:0]  bit_idx_o;
  logic [63:0] ct_hi_o, ct_lo_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  fsr_round_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i), .start_i(start_i),
    .pt_hi_i(pt_hi_i), .pt_lo_i(pt_lo_i), .key_bit_i(key_bit_i),
    .round_lsb_i(round_lsb_i), .final_i(final_i), .busy_o(busy_o),
    .bit_idx_o(bit_idx_o), .round_end_o(round_end_o), .fbit_o(fbit_o),
    .done_o(done_o), .ct_hi_o(ct_hi_o), .ct_lo_o(ct_lo_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Word size per code, written as arithmetic on the code (R1).
  function automatic int size_of(input int c);
    int lv;
    lv = (c >= 8) ? 4 : c / 2;
    return (lv < 3) ? 16 + 8 * lv : 48 + 16 * (lv - 3);
  endfunction

  function automatic logic [63:0] msk(input int n);
    return (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
  endfunction

  function automatic logic [63:0] rotl(input logic [63:0] x, input int s, input int n);
    return ((x << s) | (x >> (n - s))) & msk(n);
  endfunction

  function automatic logic [63:0] ref_round(input logic [63:0] u, l, k, input int n);
    return (l ^ k ^ (rotl(u, 1, n) & rotl(u, 8, n)) ^ rotl(u, 2, n)) & msk(n);
  endfunction

  function automatic logic [63:0] xs(input logic [63:0] x);
    logic [63:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 7);
    return y ^ (y << 17);
  endfunction

  logic [63:0] seed = 64'h9e37_79b9_7f4a_7c15;

  task automatic run_case(input int cfg, input logic [63:0] phi, plo,
                          input int nr, input bit poke);
    int n;
    logic [63:0] u, l, k, f, hold_hi, hold_lo;
    n = size_of(cfg);
    u = phi & msk(n);
    l = plo & msk(n);
    cfg_i = 4'(cfg); pt_hi_i = phi; pt_lo_i = plo;
    start_i = 1'b1; round_lsb_i = 1'b0; final_i = 1'b0;
    @(posedge clk); @(negedge clk);
    start_i = 1'b0;
    chk(busy_o === 1'b1 && bit_idx_o == 6'd0, "R2 busy/index", {57'd0, busy_o, bit_idx_o}, 64'h40);
    chk(done_o === 1'b0, "R10 done cleared by start", 64'(done_o), 64'd0);
    for (int r = 0; r < nr; r++) begin
      seed = xs(seed);
      k = seed & msk(n);
      f = ref_round(u, l, k, n);
      for (int j = 0; j < n; j++) begin
        key_bit_i = k[j];
        round_lsb_i = r[0];           // R8: round LSB toggles per round
        final_i = (r == nr - 1);
        if (poke && r == 0 && j == 3) begin
          start_i = 1'b1;             // R7: ignored while busy
          cfg_i = 4'((cfg % 10) + 1);
          pt_hi_i = ~phi; pt_lo_i = ~plo;
        end else begin
          start_i = 1'b0;
        end
        #1;
        chk(fbit_o === f[j], "R4 new bit", 64'(fbit_o), 64'(f[j]));
        chk(bit_idx_o == 6'(j), "R3 index", 64'(bit_idx_o), 64'(j));
        chk(round_end_o === (j == n - 1), "R3 round end", 64'(round_end_o), 64'(j == n - 1));
        @(posedge clk); @(negedge clk);
      end
      l = u;
      u = f;
    end
    start_i = 1'b0; final_i = 1'b0;
    chk(done_o === 1'b1 && busy_o === 1'b0, "R6 finish", {62'd0, done_o, busy_o}, 64'd2);
    chk(ct_hi_o === u, "R8 upper result", ct_hi_o, u);
    chk(ct_lo_o === l, "R5 lower result", ct_lo_o, l);
    hold_hi = ct_hi_o; hold_lo = ct_lo_o;
    repeat (3) @(negedge clk);
    chk(done_o === 1'b1 && ct_hi_o === hold_hi && ct_lo_o === hold_lo, "R10 hold",
        ct_hi_o, hold_hi);
  endtask

  task automatic try_bad(input int code);
    logic [63:0] h;
    h = ct_hi_o;
    cfg_i = 4'(code); pt_hi_i = '1; start_i = 1'b1;
    @(posedge clk); @(negedge clk);
    start_i = 1'b0;
    chk(busy_o === 1'b0, "R1 refused code keeps idle", 64'(busy_o), 64'd0);
    chk(done_o === 1'b1 && ct_hi_o === h, "R1 refused code keeps result", ct_hi_o, h);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R3 watchdog: got 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(busy_o === 1'b0 && done_o === 1'b0 && fbit_o === 1'b0 && round_end_o === 1'b0,
        "R9 reset flags", {60'd0, busy_o, done_o, fbit_o, round_end_o}, 64'd0);
    chk(ct_hi_o === 64'd0 && ct_lo_o === 64'd0, "R9 reset result", ct_hi_o | ct_lo_o, 64'd0);
    @(negedge clk);
    for (int c = 1; c <= 10; c++) begin
      for (int p = 0; p < 4; p++) begin
        int n;
        logic [63:0] a, b;
        n = size_of(c);
        seed = xs(seed); a = seed;
        seed = xs(seed); b = seed;
        case (p)
          0: run_case(c, a, b, 1, 1'b0);
          1: run_case(c, '1, '0, 2, 1'b0);
          2: run_case(c, 64'd1 << (n - 1), 64'd1, 3, 1'b0);
          default: run_case(c, a, b, 4, 1'b1);
        endcase
      end
    end
    try_bad(0);
    try_bad(11);
    try_bad(15);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule